// File: doc/BRIEF.md
# ISA I/O Slave Decoder with Byte-Lane Steering

This block sits between an ISA-style I/O bus and a small peripheral register file. It recognises its own 32-byte I/O window by comparing address bits 9..5 with five strap inputs, and only while the address-enable line is asserted (low). A strap tied to ground compares against 0. A strap left open is pulled up and compares against 1, so a base such as 0x2C0 (straps 10110) is reachable.

Address bits 4..0 pick the register. The width-sense input, the byte-high enable and the address LSB then decide which byte lanes carry the data. The bus is taken as synchronous to `clk`. Lane enables, read data, the register read strobe and the open-collector 16-bit-cycle pull-down are combinational from the bus inputs. Writes are captured while the write strobe is low and issued as a one-cycle register-file write pulse after its rising edge.

A register-file input `slow_flag` marks registers that need extra time. On such accesses the open-collector ready line is pulled low for a programmable number of clocks, starting in the cycle the strobe first appears.

Top module: `isa_slave_decoder`

## Requirements
- R1: The block responds (lane enables, read strobe, 16-bit-cycle pull, write capture) only when `bus_aen_n` is 0 and `bus_addr[9:5]` equals `base_strap`. Otherwise every output stays inactive and no write is issued.
- R2: `rf_addr` always equals `bus_addr[4:0]`. Width sense and byte-high enable never alter it, and `rf_waddr` is the offset captured during the write.
- R3: With `width8_sense` = 1 (8-bit bus), every access uses the lower lane only, whatever the address parity or `bhe_n` level.
- R4: With `width8_sense` = 0, `bhe_n` = 0 and an odd offset, only the upper lane is used. On reads `bus_dout[7:0]` is 0 with `lane_lo_oe` low, and on writes `rf_be` = 2'b10.
- R5: With `width8_sense` = 0, `bhe_n` = 1 and an even offset, only the lower lane is used (`rf_be` = 2'b01).
- R6: With `width8_sense` = 0 and `bhe_n` = 0, offset 0x18 (the FIFO word port) uses both lanes at once (`rf_be` = 2'b11).
- R7: Any other combination is illegal. It produces no register write, no read strobe, no lane enable and no 16-bit-cycle pull.
- R8: `cs16_pull` (1 = drive the open-collector line low) is 1 exactly while the block is selected with a legal combination that uses the upper lane. This is independent of the strobes.
- R9: While `iow_n` is low the block captures the offset, lane mask and `bus_din`. In the cycle after the clock edge that first sees `iow_n` high again, `rf_wr` pulses for one cycle with that captured offset, mask and unmodified 16-bit data.
- R10: On a selected, legal access with `slow_flag` = 1 and `wait_clks` = N > 0, `rdy_pull` is 1 from the cycle the strobe first goes low for exactly N cycles, even if the strobe ends earlier.
- R11: `rdy_pull` stays 0 on accesses with `slow_flag` = 0, on slow accesses with `wait_clks` = 0, and when the block is not accessed.
- R12: While `rst_n` is low, `rf_wr` and `rdy_pull` are 0 and, with strobes idle, no lane is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | I/O address from the bus |
| bus_aen_n | input | 1 | Address enable, active low |
| base_strap | input | 5 | Base address straps (open = 1, ground = 0) |
| width8_sense | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| bhe_n | input | 1 | Byte-high enable, active low |
| ior_n | input | 1 | Read strobe, active low |
| iow_n | input | 1 | Write strobe, active low |
| bus_din | input | 16 | Write data from the bus |
| bus_dout | output | 16 | Read data, zero on undriven lanes |
| lane_lo_oe | output | 1 | Drive enable for data bits 7..0 |
| lane_hi_oe | output | 1 | Drive enable for data bits 15..8 |
| cs16_pull | output | 1 | Pull the 16-bit-cycle line low |
| rdy_pull | output | 1 | Pull the ready line low (insert wait) |
| slow_flag | input | 1 | Register file marks the current offset as slow |
| wait_clks | input | 4 | Wait length in clocks for slow accesses |
| rf_addr | output | 5 | Current register offset |
| rf_rd | output | 1 | Register read strobe (level) |
| rf_rdata | input | 16 | Register read data |
| rf_wr | output | 1 | One-cycle register write pulse |
| rf_be | output | 2 | Lane mask of the write (bit 1 = upper) |
| rf_waddr | output | 5 | Offset of the write |
| rf_wdata | output | 16 | Data word of the write |

## Verification
Reads and writes are applied for every lane case: 8-bit accesses at both parities and both `bhe_n` levels, 16-bit even-low, odd-high and FIFO-word accesses, and both illegal 16-bit mixes. Lane enables, zeroed lanes and byte masks therefore show whether parity, `bhe_n` and the FIFO offset are each decoded. Accesses that miss the strap window by one bit, or that arrive with address enable high, separate the compare from the enable qualification. A sweep of all 32 offsets checks that the offset passes through untouched. Slow accesses use several wait lengths, including zero and a strobe shorter than the wait, against fast accesses, so the model tells a correct wait count from a count tied to the strobe.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  localparam int LANE_W  = 8;
  localparam int N_LANES = 2;
  localparam int BUS_W   = LANE_W * N_LANES;

  typedef struct packed {
    logic legal;
    logic hi;
    logic lo;
  } lane_sel_t;

  // Lane choice from width sense, byte-high enable, address LSB and the
  // word-port flag. Anything not covered is reported as illegal.
  function automatic lane_sel_t steer_lanes(input logic narrow,
                                            input logic bhe_n,
                                            input logic a0,
                                            input logic is_word_port);
    lane_sel_t r;
    r = '0;
    if (narrow) begin
      r.legal = 1'b1;
      r.lo    = 1'b1;
    end else if (!bhe_n && is_word_port) begin
      r.legal = 1'b1;
      r.lo    = 1'b1;
      r.hi    = 1'b1;
    end else if (!bhe_n && a0) begin
      r.legal = 1'b1;
      r.hi    = 1'b1;
    end else if (bhe_n && !a0) begin
      r.legal = 1'b1;
      r.lo    = 1'b1;
    end
    return r;
  endfunction

  // Counter load for a wait of n clocks, the first of which is the
  // cycle that starts the access.
  function automatic logic [3:0] wait_load(input logic [3:0] n);
    return n - 4'd1;
  endfunction

endpackage

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 5
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    aen_n,
  input  logic [ADDR_W-OFS_W-1:0] strap,
  output logic                    hit
);
  localparam int BASE_W = ADDR_W - OFS_W;

  logic [BASE_W-1:0] diff;

  // A grounded strap reads 0 and an open one reads 1, so the straps are
  // compared bit for bit with the upper address.
  genvar g;
  generate
    for (g = 0; g < BASE_W; g++) begin : g_cmp
      assign diff[g] = addr[OFS_W+g] ^ strap[g];
    end
  endgenerate

  assign hit = !aen_n && (diff == '0);
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
  import isa_dec_pkg::*;
#(
  parameter int OFS_W    = 5,
  parameter int WORD_OFS = 24
) (
  input  logic             hit,
  input  logic             narrow,
  input  logic             bhe_n,
  input  logic [OFS_W-1:0] ofs,
  input  logic             ior_n,
  input  logic [BUS_W-1:0] rdata,
  output lane_sel_t        lanes,
  output logic             access_ok,
  output logic [N_LANES-1:0] oe,
  output logic [BUS_W-1:0] dout,
  output logic             cs16_pull
);
  localparam logic [OFS_W-1:0] WORD_OFS_L = OFS_W'(WORD_OFS);

  logic read_act;

  assign lanes     = steer_lanes(narrow, bhe_n, ofs[0], ofs == WORD_OFS_L);
  assign access_ok = hit && lanes.legal;
  assign read_act  = access_ok && !ior_n;
  assign cs16_pull = access_ok && lanes.hi;

  assign oe[0] = read_act && lanes.lo;
  assign oe[1] = read_act && lanes.hi;

  genvar g;
  generate
    for (g = 0; g < N_LANES; g++) begin : g_lane
      assign dout[g*LANE_W +: LANE_W] = oe[g] ? rdata[g*LANE_W +: LANE_W]
                                              : '0;
    end
  endgenerate
endmodule

// File: rtl/isa_wait_gen.sv
module isa_wait_gen
  import isa_dec_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_ok,
  input  logic              slow,
  input  logic              strobe_act,
  input  logic [WAIT_W-1:0] wait_clks,
  output logic              start_evt,
  output logic              rdy_pull
);
  logic [WAIT_W-1:0] cnt;
  logic              strobe_q;

  assign start_evt = access_ok && slow && strobe_act && !strobe_q &&
                     (wait_clks != '0) && (cnt == '0);
  assign rdy_pull  = start_evt || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_act;
      if (start_evt) begin
        cnt <= WAIT_W'(wait_load(4'(wait_clks)));
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/isa_slave_decoder.sv
module isa_slave_decoder
  import isa_dec_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int OFS_W    = 5,
  parameter int WORD_OFS = 24,
  parameter int WAIT_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_aen_n,
  input  logic [ADDR_W-OFS_W-1:0] base_strap,
  input  logic                    width8_sense,
  input  logic                    bhe_n,
  input  logic                    ior_n,
  input  logic                    iow_n,
  input  logic [BUS_W-1:0]        bus_din,
  output logic [BUS_W-1:0]        bus_dout,
  output logic                    lane_lo_oe,
  output logic                    lane_hi_oe,
  output logic                    cs16_pull,
  output logic                    rdy_pull,
  input  logic                    slow_flag,
  input  logic [WAIT_W-1:0]       wait_clks,
  output logic [OFS_W-1:0]        rf_addr,
  output logic                    rf_rd,
  input  logic [BUS_W-1:0]        rf_rdata,
  output logic                    rf_wr,
  output logic [N_LANES-1:0]      rf_be,
  output logic [OFS_W-1:0]        rf_waddr,
  output logic [BUS_W-1:0]        rf_wdata
);
  // Named internal events, also observed by the checker.
  logic               sel_hit;
  logic               access_ok;
  logic               strobe_act;
  logic               wait_start;
  logic               wr_rise;
  lane_sel_t          lanes;
  logic [N_LANES-1:0] oe;

  // Write capture state.
  logic               iow_q;
  logic               cap_valid;
  logic [N_LANES-1:0] cap_be;
  logic [OFS_W-1:0]   cap_ofs;
  logic [BUS_W-1:0]   cap_data;

  isa_addr_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
    .addr  (bus_addr),
    .aen_n (bus_aen_n),
    .strap (base_strap),
    .hit   (sel_hit)
  );

  isa_lane_steer #(.OFS_W(OFS_W), .WORD_OFS(WORD_OFS)) u_steer (
    .hit       (sel_hit),
    .narrow    (width8_sense),
    .bhe_n     (bhe_n),
    .ofs       (bus_addr[OFS_W-1:0]),
    .ior_n     (ior_n),
    .rdata     (rf_rdata),
    .lanes     (lanes),
    .access_ok (access_ok),
    .oe        (oe),
    .dout      (bus_dout),
    .cs16_pull (cs16_pull)
  );

  assign strobe_act = !ior_n || !iow_n;

  isa_wait_gen #(.WAIT_W(WAIT_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .access_ok  (access_ok),
    .slow       (slow_flag),
    .strobe_act (strobe_act),
    .wait_clks  (wait_clks),
    .start_evt  (wait_start),
    .rdy_pull   (rdy_pull)
  );

  assign lane_lo_oe = oe[0];
  assign lane_hi_oe = oe[1];
  assign rf_addr    = bus_addr[OFS_W-1:0];
  assign rf_rd      = access_ok && !ior_n;
  assign wr_rise    = !iow_q && iow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_q     <= 1'b1;
      cap_valid <= 1'b0;
      cap_be    <= '0;
      cap_ofs   <= '0;
      cap_data  <= '0;
      rf_wr     <= 1'b0;
      rf_be     <= '0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
    end else begin
      iow_q <= iow_n;
      if (!iow_n) begin
        cap_valid <= access_ok;
        cap_be    <= {lanes.hi, lanes.lo};
        cap_ofs   <= bus_addr[OFS_W-1:0];
        cap_data  <= bus_din;
      end
      rf_wr <= wr_rise && cap_valid;
      if (wr_rise && cap_valid) begin
        rf_be    <= cap_be;
        rf_waddr <= cap_ofs;
        rf_wdata <= cap_data;
      end
    end
  end
endmodule

// File: rtl/isa_slave_decoder_chk.sv
module isa_slave_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_aen_n,
  input logic       width8_sense,
  input logic       ior_n,
  input logic       iow_n,
  input logic       slow_flag,
  input logic       sel_hit,
  input logic       lane_lo_oe,
  input logic       lane_hi_oe,
  input logic       cs16_pull,
  input logic       rdy_pull,
  input logic       rf_wr,
  input logic [1:0] rf_be
);
  p_drive_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_lo_oe || lane_hi_oe || cs16_pull) |-> (sel_hit && !bus_aen_n));

  p_drive_needs_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_lo_oe || lane_hi_oe) |-> !ior_n);

  p_narrow_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    width8_sense |-> (!lane_hi_oe && !cs16_pull));

  p_write_has_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (rf_be != 2'b00));

  p_write_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> ($past(iow_n) && !$past(iow_n, 2)));

  p_write_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr);

  p_wait_starts_on_slow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pull) |-> (slow_flag && (!ior_n || !iow_n)));
endmodule

bind isa_slave_decoder isa_slave_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_aen_n    (bus_aen_n),
  .width8_sense (width8_sense),
  .ior_n        (ior_n),
  .iow_n        (iow_n),
  .slow_flag    (slow_flag),
  .sel_hit      (sel_hit),
  .lane_lo_oe   (lane_lo_oe),
  .lane_hi_oe   (lane_hi_oe),
  .cs16_pull    (cs16_pull),
  .rdy_pull     (rdy_pull),
  .rf_wr        (rf_wr),
  .rf_be        (rf_be)
);

// File: tb/isa_slave_decoder_test.sv
`timescale 1ns/1ps
module isa_slave_decoder_test;

  localparam logic [4:0] STRAP = 5'b10110;  // base 0x2C0

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_aen_n;
  logic        width8_sense;
  logic        bhe_n;
  logic        ior_n;
  logic        iow_n;
  logic [15:0] bus_din;
  logic [15:0] bus_dout;
  logic        lane_lo_oe;
  logic        lane_hi_oe;
  logic        cs16_pull;
  logic        rdy_pull;
  logic        slow_flag;
  logic [3:0]  wait_clks;
  logic [4:0]  rf_addr;
  logic        rf_rd;
  logic [15:0] rf_rdata;
  logic        rf_wr;
  logic [1:0]  rf_be;
  logic [4:0]  rf_waddr;
  logic [15:0] rf_wdata;

  always #2.5 clk = ~clk;

  // Register file stand-in: data pattern derived from the offset.
  assign rf_rdata = {3'b101, rf_addr, 3'b010, rf_addr};

  isa_slave_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen_n(bus_aen_n),
    .base_strap(STRAP), .width8_sense(width8_sense), .bhe_n(bhe_n),
    .ior_n(ior_n), .iow_n(iow_n), .bus_din(bus_din), .bus_dout(bus_dout),
    .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe), .cs16_pull(cs16_pull),
    .rdy_pull(rdy_pull), .slow_flag(slow_flag), .wait_clks(wait_clks),
    .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_rdata(rf_rdata), .rf_wr(rf_wr),
    .rf_be(rf_be), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  int  vectors = 0;
  int  misses  = 0;
  bit  running = 0;
  bit  done    = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference lane table: {legal, hi, lo}.
  function automatic logic [2:0] ref_lanes(input logic nar, input logic bhe,
                                           input logic [4:0] ofs);
    logic word;
    word = (ofs == 5'd24);
    if (nar) return 3'b101;
    case ({bhe, ofs[0]})
      2'b00:   return word ? 3'b111 : 3'b000;
      2'b01:   return 3'b110;
      2'b10:   return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  // Model state.
  int          m_cnt;
  bit          m_stq, m_iowq, m_capv, e_wr;
  logic [1:0]  m_capbe, e_be;
  logic [4:0]  m_capa, e_waddr;
  logic [15:0] m_capd, e_wdata;

  function automatic bit m_sel();
    return !bus_aen_n && (bus_addr[9:5] == STRAP);
  endfunction

  function automatic bit m_start(input bit ok);
    return ok && slow_flag && (!ior_n || !iow_n) && !m_stq &&
           (wait_clks != 0) && (m_cnt == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_stq = 0; m_iowq = 1; m_capv = 0; e_wr = 0;
      m_capbe = 0; m_capa = 0; m_capd = 0; e_be = 0; e_waddr = 0; e_wdata = 0;
    end else begin
      logic [2:0] ln;
      bit ok, st;
      ln = ref_lanes(width8_sense, bhe_n, bus_addr[4:0]);
      ok = m_sel() && ln[2];
      st = m_start(ok);
      if (st) m_cnt = int'(wait_clks) - 1;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_stq = !ior_n || !iow_n;
      e_wr = (!m_iowq && iow_n && m_capv);
      if (e_wr) begin e_be = m_capbe; e_waddr = m_capa; e_wdata = m_capd; end
      if (!iow_n) begin
        m_capv = ok; m_capbe = ln[1:0]; m_capa = bus_addr[4:0]; m_capd = bus_din;
      end
      m_iowq = iow_n;
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      logic [2:0] ln;
      bit ok, rd, sel;
      logic [15:0] rdv, exd;
      string t;
      sel = m_sel();
      ln  = ref_lanes(width8_sense, bhe_n, bus_addr[4:0]);
      ok  = sel && ln[2];
      rd  = ok && !ior_n;
      rdv = {3'b101, bus_addr[4:0], 3'b010, bus_addr[4:0]};
      exd = {(rd && ln[1]) ? rdv[15:8] : 8'h00, (rd && ln[0]) ? rdv[7:0] : 8'h00};
      if (!sel)              t = "R1";
      else if (width8_sense) t = "R3";
      else if (!ln[2])       t = "R7";
      else if (ln[1:0] == 2'b11) t = "R6";
      else if (ln[1])        t = "R4";
      else                   t = "R5";
      chk(t, "lane_oe", {30'd0, lane_hi_oe, lane_lo_oe}, {30'd0, rd && ln[1], rd && ln[0]});
      chk(t, "dout", 32'(bus_dout), 32'(exd));
      chk(t, "rf_rd", 32'(rf_rd), 32'(rd));
      chk("R8", "cs16_pull", 32'(cs16_pull), 32'(ok && ln[1]));
      chk("R2", "rf_addr", 32'(rf_addr), 32'(bus_addr[4:0]));
      chk(slow_flag ? "R10" : "R11", "rdy_pull", 32'(rdy_pull),
          32'(m_start(ok) || (m_cnt > 0)));
      chk("R9", "rf_wr", 32'(rf_wr), 32'(e_wr));
      if (e_wr) begin
        chk("R9", "rf_be", 32'(rf_be), 32'(e_be));
        chk("R2", "rf_waddr", 32'(rf_waddr), 32'(e_waddr));
        chk("R9", "rf_wdata", 32'(rf_wdata), 32'(e_wdata));
      end
    end
  end

  task automatic acc(input bit rd, input logic [9:0] a, input bit bhe,
                     input bit nar, input logic [15:0] d, input int hold,
                     input bit slow, input logic [3:0] w, input bit aen);
    @(posedge clk); #1;
    bus_addr = a; bus_aen_n = aen; bhe_n = bhe; width8_sense = nar;
    bus_din = d; slow_flag = slow; wait_clks = w;
    if (rd) ior_n = 1'b0; else iow_n = 1'b0;
    repeat (hold) @(posedge clk);
    #1; ior_n = 1'b1; iow_n = 1'b1;
    @(posedge clk); #1;
    bus_aen_n = 1'b1; bus_addr = '0; slow_flag = 1'b0; bhe_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = '0; bus_aen_n = 1; width8_sense = 0; bhe_n = 1;
    ior_n = 1; iow_n = 1; bus_din = '0; slow_flag = 0; wait_clks = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R12", "rf_wr in reset", 32'(rf_wr), 0);
      chk("R12", "rdy_pull in reset", 32'(rdy_pull), 0);
      chk("R12", "oe in reset", {30'd0, lane_hi_oe, lane_lo_oe}, 0);
    end
    @(posedge clk); #1; rst_n = 1;
    running = 1;

    // Reads across lane cases (R3..R7)
    acc(1, 10'h2C2, 1, 0, 0, 2, 0, 0, 0);   // R5 even, low lane
    acc(1, 10'h2C3, 0, 0, 0, 2, 0, 0, 0);   // R4 odd, high lane
    acc(1, 10'h2D8, 0, 0, 0, 2, 0, 0, 0);   // R6 word port
    acc(1, 10'h2D9, 0, 0, 0, 1, 0, 0, 0);   // R4 odd neighbour
    acc(1, 10'h2C5, 1, 1, 0, 2, 0, 0, 0);   // R3 narrow odd
    acc(1, 10'h2C6, 0, 1, 0, 2, 0, 0, 0);   // R3 narrow, bhe ignored
    acc(1, 10'h2C1, 1, 0, 0, 2, 0, 0, 0);   // R7 odd without bhe
    acc(1, 10'h2C4, 0, 0, 0, 2, 0, 0, 0);   // R7 even with bhe
    // Selection (R1)
    acc(1, 10'h2E2, 1, 0, 0, 2, 0, 0, 0);   // one strap bit off
    acc(1, 10'h0C2, 1, 0, 0, 2, 0, 0, 0);   // top bit off
    acc(1, 10'h2C2, 1, 0, 0, 2, 0, 0, 1);   // address enable high
    acc(0, 10'h2C2, 1, 0, 16'hBEEF, 2, 0, 0, 1);
    // Writes (R9 with lane masks R3..R7)
    acc(0, 10'h2CA, 1, 0, 16'h1234, 2, 0, 0, 0);
    acc(0, 10'h2CB, 0, 0, 16'h5678, 1, 0, 0, 0);
    acc(0, 10'h2D8, 0, 0, 16'hA55A, 3, 0, 0, 0);
    acc(0, 10'h2CF, 0, 1, 16'h0F0F, 2, 0, 0, 0);
    acc(0, 10'h2C7, 1, 0, 16'hDEAD, 2, 0, 0, 0);  // R7 no write
    acc(0, 10'h2CC, 0, 0, 16'hCAFE, 2, 0, 0, 0);  // R7 no write
    acc(0, 10'h2F0, 1, 0, 16'h7777, 2, 0, 0, 0);  // R1 miss
    // Wait insertion (R10, R11)
    acc(1, 10'h2CA, 1, 0, 0, 5, 1, 3, 0);
    acc(0, 10'h2CA, 1, 0, 16'h4444, 4, 1, 1, 0);
    acc(1, 10'h2CE, 1, 0, 0, 2, 1, 6, 0);     // strobe shorter than wait
    acc(1, 10'h2CE, 1, 0, 0, 3, 1, 0, 0);     // zero wait
    acc(1, 10'h2CE, 1, 0, 0, 3, 0, 9, 0);     // fast register
    acc(1, 10'h2EE, 1, 0, 0, 3, 1, 4, 0);     // slow but not selected
    acc(0, 10'h2C9, 1, 0, 16'h1111, 3, 1, 5, 0); // slow but illegal
    // Offset sweep (R2)
    for (int i = 0; i < 32; i++) begin
      acc(1, {STRAP, 5'(i)}, (i % 2 == 0), 0, 0, 1, 0, 0, 0);
      acc(0, {STRAP, 5'(i)}, (i % 2 == 0), 0, 16'(i * 16'h0101), 1, 0, 0, 0);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule